// File: doc/BRIEF.md
# External Event Counter with Buffered Compare-Clear

This block counts qualified transitions on an asynchronous external event line rather than clock cycles. Software selects which transitions qualify (none, rising, falling or both) and writes a period value into a compare register. When counting begins, that value is copied into a compare buffer. The counter advances once per qualified transition. When it has reached the buffered value, the next qualified transition clears it to zero and raises a one-clock interrupt pulse, so with compare value N an interrupt arrives every N+1 qualified transitions.

Counting happens only while the enable bit is set and the mode field selects event counting (value 001). Otherwise the counter rests at all-ones. Raising the enable (in the event mode) moves the counter from all-ones to zero and loads the buffer. Every match-clear reloads the buffer from the compare register. A compare value written during a period therefore takes effect from the next period.

Top module: `evt_cmp_counter`

## Requirements
- R1: After reset, and on every clock edge where the enable input is 0, the count output is FFFFH. During reset the interrupt output is 0.
- R2: On the first clock edge at which the block becomes active (enable 1 and mode 001), the count becomes 0000H and the compare register value is copied into the compare buffer.
- R3: The block counts only while enable is 1 and the mode field equals 3'b001. With any other mode value the count output stays at FFFFH and event transitions have no effect.
- R4: Edge-select encoding: 2'b00 no transition qualifies, 2'b01 rising only, 2'b10 falling only, 2'b11 both.
- R5: The event input passes through a two-flop synchronizer. A qualified transition driven on the input is reflected in the count output on the third rising clock edge after the change, and not before.
- R6: A qualified transition that arrives while the count equals the compare buffer clears the count to 0000H instead of incrementing it. It also drives the interrupt output high for exactly that one clock. With compare value N, the block raises one interrupt per N+1 qualified transitions.
- R7: Every match-clear reloads the compare buffer from the compare register. A compare value written mid-period does not change the current period and governs the next one.
- R8: When the write strobe is 1 on a clock edge, the compare register takes the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Count enable |
| mode_sel | input | 3 | Operating mode; 3'b001 selects event counting |
| edge_sel | input | 2 | Qualifying transition select |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | 16 | Compare register write data |
| evt_in | input | 1 | Asynchronous external event line |
| count_q | output | 16 | Current count value |
| match_irq | output | 1 | One-clock compare-match interrupt pulse |

## Verification
An input transition shows on the count output three rising clock edges after it is driven: two edges for the synchronizer and one for the counter register. The interrupt pulse appears on the same edge as the clear. Enable and reset act on the count after a single edge. The bench drives all inputs on falling edges. For each vector it waits at least four edges after the final transition before it samples the count. It counts interrupt pulses at every falling edge, so a single-cycle pulse cannot be missed or counted twice. A directed check samples the falling edges after the second and third rising edges to confirm the exact latency.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam logic [2:0] MODE_EVENT_COUNT = 3'b001;
endpackage

// File: rtl/evc_edge_qual.sv
module evc_edge_qual
  import evc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       evt_in,
  input  logic [1:0] edge_sel,
  output logic       evt_valid
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] shreg;
  logic            cur_lvl, prev_lvl, rise, fall;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[SH_W-2:0], evt_in};
  end

  assign cur_lvl  = shreg[SYNC_STAGES-1];
  assign prev_lvl = shreg[SYNC_STAGES];
  assign rise     = cur_lvl & ~prev_lvl;
  assign fall     = ~cur_lvl & prev_lvl;

  always_comb begin
    unique case (edge_mode_e'(edge_sel))
      EDGE_RISE: evt_valid = rise;
      EDGE_FALL: evt_valid = fall;
      EDGE_BOTH: evt_valid = rise | fall;
      default:   evt_valid = 1'b0;
    endcase
  end

  // A qualified transition needs the synchronized level to differ from its predecessor.
  assert_valid_needs_change_R4: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> (shreg[SYNC_STAGES-1] != shreg[SYNC_STAGES]));
  assert_none_masks_R4: assert property (@(posedge clk) disable iff (rst)
    (edge_sel == 2'b00) |-> !evt_valid);
endmodule

// File: rtl/evc_cmp_buffer.sv
module evc_cmp_buffer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             load,
  output logic [CNT_W-1:0] cmp_reg,
  output logic [CNT_W-1:0] cmp_buf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_reg <= '0;
      cmp_buf <= '0;
    end else begin
      if (cmp_wr) cmp_reg <= cmp_wdata;
      if (load)   cmp_buf <= cmp_reg;
    end
  end

  assert_wr_takes_R8: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> (cmp_reg == $past(cmp_wdata)));
  assert_buf_holds_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cmp_buf));
endmodule

// File: rtl/evc_count_core.sv
module evc_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             evt_valid,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic             load_buf,
  output logic [CNT_W-1:0] count_q,
  output logic             match_irq
);
  localparam logic [CNT_W-1:0] IDLE_VAL = '1;

  logic active_d, start, hit, clear;

  assign start    = active & ~active_d;
  assign hit      = (count_q == cmp_buf);
  assign clear    = active & ~start & evt_valid & hit;
  assign load_buf = start | clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_d  <= 1'b0;
      count_q   <= IDLE_VAL;
      match_irq <= 1'b0;
    end else begin
      active_d  <= active;
      match_irq <= clear;
      if (!active)        count_q <= IDLE_VAL;
      else if (start)     count_q <= '0;
      else if (clear)     count_q <= '0;
      else if (evt_valid) count_q <= count_q + 1'b1;
    end
  end

  assert_idle_allones_R1: assert property (@(posedge clk) disable iff (rst)
    !active |=> (count_q == IDLE_VAL));
  assert_start_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (active && !active_d) |=> (count_q == '0));
  assert_irq_clears_R6: assert property (@(posedge clk) disable iff (rst)
    match_irq |-> (count_q == '0));
  assert_bounded_by_buf_R6: assert property (@(posedge clk) disable iff (rst)
    active_d |-> (count_q <= cmp_buf));
  assert_hold_without_edge_R5: assert property (@(posedge clk) disable iff (rst)
    (active && active_d && !evt_valid) |=> $stable(count_q));
endmodule

// File: rtl/evt_cmp_counter.sv
module evt_cmp_counter
  import evc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [2:0]       mode_sel,
  input  logic [1:0]       edge_sel,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             evt_in,
  output logic [CNT_W-1:0] count_q,
  output logic             match_irq
);
  logic             active, evt_valid, load_buf;
  logic [CNT_W-1:0] cmp_reg, cmp_buf;

  assign active = run_en & (mode_sel == MODE_EVENT_COUNT);

  evc_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .evt_in(evt_in), .edge_sel(edge_sel),
    .evt_valid(evt_valid)
  );

  evc_cmp_buffer #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .load(load_buf), .cmp_reg(cmp_reg), .cmp_buf(cmp_buf)
  );

  evc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .active(active), .evt_valid(evt_valid),
    .cmp_buf(cmp_buf), .load_buf(load_buf), .count_q(count_q),
    .match_irq(match_irq)
  );

  assert_wrong_mode_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_sel != MODE_EVENT_COUNT) |=> (count_q == '1));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !match_irq);
endmodule

// File: tb/evt_cmp_counter_test.sv
module evt_cmp_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {edge_sel[2], cmp[16], toggles[8], exp_count[16], exp_irqs[8]}
  localparam logic [49:0] VEC [NVEC] = '{
    {2'b01, 16'd3,      8'd10, 16'd1, 8'd1},
    {2'b10, 16'd3,      8'd10, 16'd1, 8'd1},
    {2'b11, 16'd3,      8'd10, 16'd2, 8'd2},
    {2'b00, 16'd3,      8'd8,  16'd0, 8'd0},
    {2'b11, 16'd0,      8'd6,  16'd0, 8'd6},
    {2'b01, 16'd7,      8'd16, 16'd0, 8'd1},
    {2'b11, 16'd4,      8'd9,  16'd4, 8'd1},
    {2'b01, 16'hFFFF,   8'd6,  16'd3, 8'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic [2:0]  mode_sel = 3'b001;
  logic [1:0]  edge_sel = 2'b01;
  logic        cmp_wr = 1'b0;
  logic [15:0] cmp_wdata = '0;
  logic        evt_in = 1'b0;
  logic [15:0] count_q;
  logic        match_irq;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_cmp_counter uut (
    .clk(clk), .rst(rst), .run_en(run_en), .mode_sel(mode_sel),
    .edge_sel(edge_sel), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .evt_in(evt_in), .count_q(count_q), .match_irq(match_irq)
  );

  always @(negedge clk) if (!rst && match_irq) irq_seen++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cmp(input logic [15:0] v);
    cmp_wr = 1'b1; cmp_wdata = v;
    cycles(1);
    cmp_wr = 1'b0;
  endtask

  task automatic toggles(input int n);
    for (int i = 0; i < n; i++) begin
      evt_in = ~evt_in;
      cycles(2);
    end
    cycles(4);
  endtask

  task automatic restart(input logic [1:0] es, input logic [15:0] cmp);
    run_en = 1'b0; evt_in = 1'b0; mode_sel = 3'b001;
    cycles(5);
    edge_sel = es;
    write_cmp(cmp);
    run_en = 1'b1;
    cycles(2);
    irq_seen = 0;
  endtask

  initial begin
    cycles(3);
    // R1: reset state
    check("R1 reset count", count_q, 16'hFFFF);
    check("R1 reset irq", match_irq, 0);
    rst = 1'b0;
    cycles(2);
    check("R1 disabled count", count_q, 16'hFFFF);

    // R2: start moves count to zero after one edge
    write_cmp(16'd3);
    run_en = 1'b1;
    cycles(1);
    check("R2 start zero", count_q, 0);

    // Vector table: R4 edge select, R6 period, R8 compare write
    for (int v = 0; v < NVEC; v++) begin
      restart(VEC[v][49:48], VEC[v][47:32]);
      toggles(int'(VEC[v][31:24]));
      check($sformatf("R4/R6 vec%0d count", v), count_q, int'(VEC[v][23:8]));
      check($sformatf("R6 vec%0d irqs", v), irq_seen, int'(VEC[v][7:0]));
    end

    // R5: latency of exactly three rising edges
    restart(2'b01, 16'd9);
    evt_in = 1'b1;
    cycles(2);
    check("R5 not before third edge", count_q, 0);
    cycles(1);
    check("R5 at third edge", count_q, 1);

    // R7: mid-period write applies to next period
    restart(2'b01, 16'd5);
    write_cmp(16'd1);
    toggles(4);
    check("R7 old period still active", count_q, 2);
    toggles(8);
    check("R7 first period clear", count_q, 0);
    check("R7 one irq", irq_seen, 1);
    toggles(4);
    check("R7 new period clear", count_q, 0);
    check("R7 second irq", irq_seen, 2);
    toggles(2);
    check("R7 count after new clear", count_q, 1);

    // R3: wrong mode holds all-ones and ignores edges
    restart(2'b11, 16'd3);
    mode_sel = 3'b010;
    cycles(1);
    check("R3 wrong mode count", count_q, 16'hFFFF);
    toggles(6);
    check("R3 wrong mode edges ignored", count_q, 16'hFFFF);
    check("R3 wrong mode no irq", irq_seen, 0);

    // R1: disable mid-count returns to all-ones
    restart(2'b11, 16'd9);
    toggles(3);
    check("R1 counting before disable", count_q, 3);
    run_en = 1'b0;
    cycles(1);
    check("R1 disable to all-ones", count_q, 16'hFFFF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule